// File: doc/BRIEF.md
# Multi-format stereo audio serial receiver

This block takes a stereo audio stream from a three-wire serial port (bit clock, frame clock, serial data) and turns it into parallel left and right samples for logic that runs on a separate system clock. A 2-bit format input selects one of four framings. Two formats place the word at the end of each frame-clock half and two place it at the start. The same shift and capture engine serves all four.

Every sample comes out as a 24-bit two's-complement word, aligned to the top bit. A 16-bit word fills the upper 16 bits, and the lower 8 bits are zero. The engine runs on the rising bit-clock edge and raises a toggle once each stereo pair is complete. A synchroniser carries that toggle into the system clock domain. There, the pair is latched onto the output ports and a one-cycle valid strobe is raised.

The frame clock and the format are expected to be stable around rising bit-clock edges. The system clock is expected to be several times faster than the bit clock. Whenever the format is changed, a reset must follow the change.

Top module: `audio_serial_rx`

## Requirements
- R1: With format code 00, each sample is the 16 bits received just before the frame-clock transition that ends its half. The sample is output as {bits, 8'h00}, and any earlier bits in that half are ignored.
- R2: With format code 01, each sample is the 24 bits received just before the frame-clock transition that ends its half. Any earlier bits in that half are ignored.
- R3: With format code 10, each sample is the first 24 bits of its half, starting with the bit sampled on the first rising bit-clock edge after the frame-clock transition. Later bits in that half are ignored.
- R4: With format code 11, capture starts one bit clock after the frame-clock transition. With 16 bit clocks per half, the 16 bits received form the sample, output as {bits, 8'h00}. With 24 or 32 bit clocks per half, the first 24 bits form the sample.
- R5: For codes 00, 01 and 10, the left channel is the half in which the frame clock is high. For code 11, the left channel is the half in which the frame clock is low.
- R6: Serial data is read MSB first, as two's complement, on the rising bit-clock edge only.
- R7: `samp_valid` is high for exactly one system clock cycle per completed stereo frame, after the right half ends. No pulse is produced for the first frame-clock half after reset, because that half may be partial.
- R8: While `rst_n` is low and clocks run, `samp_valid` is 0 and both sample outputs are 0.
- R9: `samp_l` and `samp_r` change only in a cycle where `samp_valid` is high, and they hold their values between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; also passed through a synchroniser into the bit-clock domain |
| bclk | input | 1 | Serial bit clock |
| lrck | input | 1 | Frame clock (channel select) |
| sdata | input | 1 | Serial audio data |
| fmt | input | 2 | Framing select: 00 16-bit end-aligned, 01 24-bit end-aligned, 10 24-bit start-aligned, 11 I2S-style |
| samp_l | output | 24 | Left sample, aligned to the top bit |
| samp_r | output | 24 | Right sample, aligned to the top bit |
| samp_valid | output | 1 | One-cycle strobe marking a new stereo pair |

## Verification
The bench sweeps every format at each legal bit-clock rate. It pads unused slots with ones, so a receiver that counted from the wrong end of a half would pick up the filler bits. Full-scale positive, full-scale negative, zero and all-ones words are included, which exposes a shift that is off by one bit or a sign bit that is dropped. In I2S-style framing at 24 bit clocks per half, the last bit of each word spills into the next half; a design that failed to delay its frame reference would lose that LSB. Two further stimuli target specific faults: data is corrupted just after each rising bit-clock edge, which catches sampling on the wrong edge, and the run starts with a partial half, which catches a missing or duplicated strobe.

// File: rtl/asr_pkg.sv
// Package: shared types for the audio serial receiver.
// Assumes nothing beyond a 2-bit framing code.
package asr_pkg;

    // Framing code; the encoding is visible on the top-level fmt port.
    typedef enum logic [1:0] {
        FMT_END16   = 2'b00,
        FMT_END24   = 2'b01,
        FMT_START24 = 2'b10,
        FMT_I2S     = 2'b11
    } asr_fmt_e;

endpackage

// File: rtl/asr_sync_bit.sv
// Module: multi-flop synchroniser for a single slowly changing bit.
// Assumes the input holds each value for several destination clock cycles.
// It has no reset, so it can also carry a reset into another clock domain.
module asr_sync_bit #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the input through the synchroniser chain.
    always_ff @(posedge clk) begin
        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/asr_shift_engine.sv
// Module: bit-clock-domain frame parser.
// For end-aligned formats it keeps a running shift register and takes the
// trailing bits when the frame reference changes. For start-aligned and
// I2S-style formats it writes each bit into a word by position, counting
// from the frame reference change.
// I2S-style framing uses the frame clock delayed by one bit clock as its
// reference, so it reduces to start-aligned capture with inverted polarity.
// Assumes lrck and sdata are stable around rising bclk edges.
module asr_shift_engine
    import asr_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int SHORT_W  = 16
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  asr_fmt_e            fmt,
    input  logic                lrck,
    input  logic                sdata,
    output logic [SAMPLE_W-1:0] left_word,
    output logic [SAMPLE_W-1:0] right_word,
    output logic                frame_tgl
);
    localparam int CNT_W = $clog2(SAMPLE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SAMPLE_W);
    localparam logic [SAMPLE_W-1:0] TOP_BIT = {1'b1, {(SAMPLE_W-1){1'b0}}};
    localparam int PAD_W = SAMPLE_W - SHORT_W;

    logic                lr_d;
    logic                ref_q;
    logic                armed;
    logic                have_left;
    logic [SAMPLE_W-1:0] shreg;
    logic [SAMPLE_W-1:0] acc;
    logic [CNT_W-1:0]    cnt;
    logic                i2s;
    logic                ref_now;
    logic                edge_seen;
    logic                ended_left;
    logic [SAMPLE_W-1:0] word;

    // Choose the frame reference and detect the end of a half.
    always_comb begin
        i2s        = (fmt == FMT_I2S);
        ref_now    = i2s ? lr_d : lrck;
        edge_seen  = (ref_now != ref_q);
        ended_left = (ref_q == ~i2s);
    end

    // Select the finished word according to the framing.
    always_comb begin
        case (fmt)
            FMT_END16: word = {shreg[SHORT_W-1:0], {PAD_W{1'b0}}};
            FMT_END24: word = shreg;
            default:   word = acc;
        endcase
    end

    // Shift, position-capture and hand finished words to the holding registers.
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            lr_d       <= lrck;
            ref_q      <= lrck;
            armed      <= 1'b0;
            have_left  <= 1'b0;
            shreg      <= '0;
            acc        <= '0;
            cnt        <= CNT_FULL;
            left_word  <= '0;
            right_word <= '0;
            frame_tgl  <= 1'b0;
        end else begin
            lr_d  <= lrck;
            ref_q <= ref_now;
            shreg <= {shreg[SAMPLE_W-2:0], sdata};
            if (edge_seen) begin
                acc   <= {sdata, {(SAMPLE_W-1){1'b0}}};
                cnt   <= CNT_W'(1);
                armed <= 1'b1;
                if (armed) begin
                    if (ended_left) begin
                        left_word <= word;
                        have_left <= 1'b1;
                    end else if (have_left) begin
                        right_word <= word;
                        frame_tgl  <= ~frame_tgl;
                    end
                end
            end else if (cnt < CNT_FULL) begin
                acc <= acc | ((TOP_BIT >> cnt) & {SAMPLE_W{sdata}});
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // R7: the pair toggle only moves at the end of a half.
    a_r7_tgl_on_edge: assert property (@(posedge bclk) disable iff (!rst_n)
        (frame_tgl != $past(frame_tgl)) |-> $past(edge_seen));

    // R7: no pair is handed over before a complete left word exists.
    a_r7_tgl_after_left: assert property (@(posedge bclk) disable iff (!rst_n)
        (frame_tgl != $past(frame_tgl)) |-> $past(have_left));

    // R3: the position counter never runs past the word width.
    a_r3_cnt_bound: assert property (@(posedge bclk) disable iff (!rst_n)
        cnt <= CNT_FULL);
endmodule

// File: rtl/asr_pair_handoff.sv
// Module: system-clock-domain latch for completed stereo pairs.
// It watches the synchronised pair toggle and, when the toggle changes,
// copies both words to the outputs and raises a one-cycle strobe.
// Assumes the words stay stable for several clk cycles after the toggle
// changes; a bit clock much slower than clk ensures this.
module asr_pair_handoff #(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tgl_s,
    input  logic [SAMPLE_W-1:0] left_word,
    input  logic [SAMPLE_W-1:0] right_word,
    output logic [SAMPLE_W-1:0] samp_l,
    output logic [SAMPLE_W-1:0] samp_r,
    output logic                samp_valid
);
    logic seen;

    // Latch a new pair on each toggle change and raise the strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen       <= tgl_s;
            samp_l     <= '0;
            samp_r     <= '0;
            samp_valid <= 1'b0;
        end else begin
            seen       <= tgl_s;
            samp_valid <= (tgl_s != seen);
            if (tgl_s != seen) begin
                samp_l <= left_word;
                samp_r <= right_word;
            end
        end
    end

    // R7: the strobe lasts exactly one cycle.
    a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        samp_valid |=> !samp_valid);

    // R9: the outputs change only together with the strobe.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((samp_l != $past(samp_l)) || (samp_r != $past(samp_r))) |-> samp_valid);
endmodule

// File: rtl/audio_serial_rx.sv
// Module: top of the multi-format stereo audio serial receiver.
// It connects the bit-clock reset synchroniser, the frame parser, the toggle
// synchroniser and the system-domain pair latch.
// Assumes a reset follows every change of fmt, and that clk is much faster
// than bclk.
module audio_serial_rx
    import asr_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int SHORT_W     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk,
    input  logic                lrck,
    input  logic                sdata,
    input  logic [1:0]          fmt,
    output logic [SAMPLE_W-1:0] samp_l,
    output logic [SAMPLE_W-1:0] samp_r,
    output logic                samp_valid
);
    logic                bclk_rst_n;
    logic                frame_tgl;
    logic                tgl_s;
    logic [SAMPLE_W-1:0] left_word;
    logic [SAMPLE_W-1:0] right_word;

    asr_sync_bit #(.STAGES(SYNC_STAGES)) u_rst_sync (
        .clk (bclk),
        .d   (rst_n),
        .q   (bclk_rst_n)
    );

    asr_shift_engine #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W)) u_engine (
        .bclk       (bclk),
        .rst_n      (bclk_rst_n),
        .fmt        (asr_fmt_e'(fmt)),
        .lrck       (lrck),
        .sdata      (sdata),
        .left_word  (left_word),
        .right_word (right_word),
        .frame_tgl  (frame_tgl)
    );

    asr_sync_bit #(.STAGES(SYNC_STAGES)) u_tgl_sync (
        .clk (clk),
        .d   (frame_tgl),
        .q   (tgl_s)
    );

    asr_pair_handoff #(.SAMPLE_W(SAMPLE_W)) u_handoff (
        .clk        (clk),
        .rst_n      (rst_n),
        .tgl_s      (tgl_s),
        .left_word  (left_word),
        .right_word (right_word),
        .samp_l     (samp_l),
        .samp_r     (samp_r),
        .samp_valid (samp_valid)
    );
endmodule

// File: tb/test_audio_serial_rx.sv
// Bench: sweeps every framing at each legal bit-clock rate and checks the
// captured pairs against words computed in the bench.
module test_audio_serial_rx;
    localparam int NF = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0;
    logic        lrck = 1'b0;
    logic        sdata = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic [23:0] samp_l;
    logic [23:0] samp_r;
    logic        samp_valid;

    int n_checks = 0;
    int n_fail = 0;
    int mon_checks = 0;
    int mon_fail = 0;
    int nvalid = 0;
    logic [23:0] got_l [16];
    logic [23:0] got_r [16];
    logic prev_valid = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    audio_serial_rx i_audio_serial_rx (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrck(lrck), .sdata(sdata),
        .fmt(fmt), .samp_l(samp_l), .samp_r(samp_r), .samp_valid(samp_valid)
    );

    // Record each strobe and check that it lasts one cycle (R7).
    always @(negedge clk) begin
        if (samp_valid) begin
            if (nvalid < 16) begin
                got_l[nvalid] = samp_l;
                got_r[nvalid] = samp_r;
            end
            nvalid = nvalid + 1;
            mon_checks = mon_checks + 1;
            if (prev_valid) begin
                mon_fail = mon_fail + 1;
                $display("FAIL R7 strobe wider than one cycle: got 1 exp 0");
            end
        end
        prev_valid = samp_valid;
    end

    task automatic check(input string req, input string what, input logic [23:0] got, input logic [23:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h exp %h", req, what, got, exp);
        end
    endtask

    function automatic logic [23:0] gen(input int k, input int w);
        logic [23:0] v;
        case (k)
            0: v = 24'h7FFFFF;
            1: v = 24'h800000;
            2: v = 24'h000000;
            3: v = 24'hFFFFFF;
            default: v = 24'((k * 32'h2D5A7 + 32'h13579B) & 32'hFFFFFF);
        endcase
        if (w == 16) v[7:0] = 8'h00;
        return v;
    endfunction

    // One bit clock: data set while low, corrupted just after the rising edge (R6).
    task automatic bit_out(input logic lr, input logic d);
        bclk = 1'b0;
        lrck = lr;
        sdata = d;
        #20 bclk = 1'b1;
        #10 sdata = ~d;
        #10;
    endtask

    // Send one half; carry holds the I2S spill bit from the previous half.
    task automatic send_half(input int f, input int h, input int w, input logic lr,
                             input logic [23:0] v, inout logic carry);
        logic [23:0] raw;
        logic b;
        raw = v >> (24 - w);
        for (int i = 0; i < h; i++) begin
            case (f)
                0, 1: b = (i >= h - w) ? raw[w-1-(i-(h-w))] : 1'b1;
                2:    b = (i < w) ? raw[w-1-i] : 1'b1;
                default: b = (i == 0) ? carry : ((i - 1 < w) ? raw[w-i] : 1'b1);
            endcase
            bit_out(lr, b);
        end
        carry = (h - 1 < w) ? raw[w-h] : 1'b1;
    endtask

    task automatic run_case(input int f, input int bpf, input string req);
        int h, w;
        logic left_lv, carry;
        logic [23:0] el [NF];
        logic [23:0] er [NF];
        h = bpf / 2;
        w = (f == 0 || (f == 3 && h == 16)) ? 16 : 24;
        left_lv = (f == 3) ? 1'b0 : 1'b1;   // R5 polarity
        carry = 1'b0;
        fmt = 2'(f);
        rst_n = 1'b0;
        for (int i = 0; i < 8; i++) bit_out(~left_lv, 1'b0);
        check("R8", "reset valid", {23'd0, samp_valid}, 24'd0);
        check("R8", "reset left", samp_l, 24'd0);
        check("R8", "reset right", samp_r, 24'd0);
        nvalid = 0;
        rst_n = 1'b1;
        // Partial right half after reset: must not produce a pulse (R7).
        for (int i = 0; i < 5; i++) bit_out(~left_lv, 1'b1);
        for (int n = 0; n < NF; n++) begin
            el[n] = gen(2 * n + f, w);
            er[n] = gen(2 * n + 1 + f + bpf, w);
            send_half(f, h, w, left_lv, el[n], carry);
            send_half(f, h, w, ~left_lv, er[n], carry);
        end
        send_half(f, h, w, left_lv, 24'h0, carry);
        send_half(f, h, w, ~left_lv, 24'h0, carry);
        check("R7", "pulse count", 24'(nvalid), 24'(NF));
        for (int n = 0; n < NF && n < nvalid; n++) begin
            check(req, $sformatf("R5 R6 left frame %0d bpf %0d", n, bpf), got_l[n], el[n]);
            check(req, $sformatf("R5 R6 right frame %0d bpf %0d", n, bpf), got_r[n], er[n]);
        end
        check("R9", "held left", samp_l, el[NF-1]);
        check("R9", "held right", samp_r, er[NF-1]);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", (n_checks + mon_checks) - (n_fail + mon_fail),
                     n_checks + mon_checks);
            $finish;
        end
    endtask

    initial begin
        run_case(0, 32, "R1");
        run_case(0, 64, "R1");
        run_case(1, 48, "R2");
        run_case(1, 64, "R2");
        run_case(2, 48, "R3");
        run_case(2, 64, "R3");
        run_case(3, 32, "R4");
        run_case(3, 48, "R4");
        run_case(3, 64, "R4");
        finish_run();
    end

    initial begin
        #700000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end
endmodule